// File: doc/BRIEF.md
# Translation Buffer Replacement Selector

This block decides which slot of a small fully associative translation buffer takes the next mapping, and it keeps the per-slot valid and used flags that the decision depends on. The buffer control presents an insert request each time it installs a translation. The request can name a slot outright. It also carries a mask of existing slots whose range overlaps the incoming mapping, and the current set of locked slots. The slot choice is combinational, so the insert logic can read the chosen index in the same cycle it raises the insert strobe. Valid flags, used flags, the used-slot count and the replacement pointer all change on the clock edge where the strobe is high.

When no slot is named, an empty slot is preferred. Slots freed by the overlap mask in the same request count as empty. When no slot is empty, a round-robin search starts just after the slot replaced last and skips locked slots. If the search finds nothing unlocked, the highest-numbered slot is overwritten and a flag reports that every slot it examined was locked. A separate touch input marks a valid slot as used, and the block keeps a running count of used slots.

Top module: `tlb_victim_sel`

## Requirements
- R1: After synchronous reset, no slot is valid, no slot is used, the used count is 0, and the replacement pointer holds NUM_ENTRIES-1, so the first search-based eviction picks slot 0.
- R2: When `force_en` is high, `victim_idx` equals `force_idx` and `all_locked` is low, whatever the valid and locked state. An insert made this way leaves the replacement pointer unchanged.
- R3: Without a forced index, if any slot is invalid or is flagged in `overlap_vec`, `victim_idx` is the lowest-numbered such slot.
- R4: Without a forced index and with no free slot, `victim_idx` is the first slot with its `lock_vec` bit low found by counting upward from pointer+1, wrapping from NUM_ENTRIES-1 to 0, and stopping before the pointer slot itself.
- R5: If R4 finds no unlocked slot, `victim_idx` is NUM_ENTRIES-1 and `all_locked` is high. This holds even when the pointer slot itself is unlocked. An insert in this state leaves the pointer unchanged.
- R6: The replacement pointer is loaded with `victim_idx` only by an insert whose slot came from the R4 search.
- R7: On an insert, every slot flagged in `overlap_vec` loses its valid and used flags. The chosen slot then becomes valid with its used flag clear.
- R8: `touch_en` with `touch_idx` sets the used flag of that slot and adds one to the count. It has no effect if the slot is invalid, already used, or if `ins_strobe` is high in the same cycle.
- R9: `used_count` always equals the number of set bits in `used_vec`, and every used slot is also valid.
- R10: `all_locked` is low whenever a slot is forced or a free slot exists.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_strobe | input | 1 | Commit an insert into the chosen slot this cycle |
| force_en | input | 1 | Use `force_idx` as the slot |
| force_idx | input | IDX_W | Slot named by the requester |
| overlap_vec | input | NUM_ENTRIES | Slots whose range overlaps the incoming mapping |
| lock_vec | input | NUM_ENTRIES | Slots that the search must not evict |
| touch_en | input | 1 | Mark one slot as used |
| touch_idx | input | IDX_W | Slot to mark as used |
| victim_idx | output | IDX_W | Chosen slot (combinational) |
| all_locked | output | 1 | Search found no unlocked slot; highest slot chosen |
| valid_vec | output | NUM_ENTRIES | Per-slot valid flags |
| used_vec | output | NUM_ENTRIES | Per-slot used flags |
| used_count | output | CNT_W | Number of used slots |

## Verification
The assertions assume that `force_idx` and `touch_idx` are below NUM_ENTRIES whenever their enables are high, and that `lock_vec` and `overlap_vec` are stable while the choice is read. With the default power-of-two slot count, every index the stimulus can draw is legal. Locked masks are drawn with a heavy bias toward set bits, so full-lock and only-pointer-unlocked states occur often. Overlap masks are kept sparse so the buffer fills and the search path runs, and forced inserts are spread through the run so they land while the pointer sits at many different positions.

// File: rtl/tlbv_pkg.sv
package tlbv_pkg;

    typedef enum logic [1:0] {
        SRC_FORCED   = 2'd0,
        SRC_FREE     = 2'd1,
        SRC_SEARCH   = 2'd2,
        SRC_FALLBACK = 2'd3
    } victim_src_e;

    function automatic int unsigned wrap_next(int unsigned cur, int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tlbv_free_pick.sv
module tlbv_free_pick #(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] free_mask,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (free_mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbv_rr_search.sv
module tlbv_rr_search
    import tlbv_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
    input  logic [IDX_W-1:0]       last_ptr,
    input  logic [NUM_ENTRIES-1:0] lock_vec,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);
    always_comb begin
        int unsigned slot;
        found = 1'b0;
        idx   = IDX_W'(NUM_ENTRIES - 1);
        slot  = int'(last_ptr);
        for (int k = 1; k < NUM_ENTRIES; k++) begin
            slot = wrap_next(slot, NUM_ENTRIES);
            if (!found && !lock_vec[slot]) begin
                found = 1'b1;
                idx   = IDX_W'(slot);
            end
        end
    end
endmodule

// File: rtl/tlbv_entry_state.sv
module tlbv_entry_state #(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_strobe,
    input  logic [IDX_W-1:0]       ins_idx,
    input  logic [NUM_ENTRIES-1:0] overlap_vec,
    input  logic                   touch_en,
    input  logic [IDX_W-1:0]       touch_idx,
    output logic [NUM_ENTRIES-1:0] valid_q,
    output logic [NUM_ENTRIES-1:0] used_q,
    output logic [CNT_W-1:0]       count_q
);
    logic [NUM_ENTRIES-1:0] ins_onehot;
    logic [NUM_ENTRIES-1:0] clear_mask;
    logic [NUM_ENTRIES-1:0] used_dropped;
    logic [CNT_W-1:0]       drop_cnt;
    logic                   touch_take;

    always_comb begin
        ins_onehot = '0;
        ins_onehot[ins_idx] = 1'b1;
        clear_mask   = ins_strobe ? (overlap_vec | ins_onehot) : '0;
        used_dropped = used_q & clear_mask;
        drop_cnt = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            drop_cnt = drop_cnt + CNT_W'(used_dropped[i]);
        end
        touch_take = touch_en && !ins_strobe && valid_q[touch_idx] && !used_q[touch_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            used_q  <= '0;
            count_q <= '0;
        end else if (ins_strobe) begin
            valid_q <= (valid_q & ~overlap_vec) | ins_onehot;
            used_q  <= used_q & ~clear_mask;
            count_q <= count_q - drop_cnt;
        end else if (touch_take) begin
            used_q[touch_idx] <= 1'b1;
            count_q <= count_q + CNT_W'(1);
        end
    end

    assert_count_matches_R9: assert property (@(posedge clk) disable iff (rst)
        count_q == CNT_W'($countones(used_q)));

    assert_used_implies_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (used_q & ~valid_q) == '0);

    assert_touch_sets_used_R8: assert property (@(posedge clk) disable iff (rst)
        touch_take |=> used_q[$past(touch_idx)]);

    assert_insert_marks_valid_R7: assert property (@(posedge clk) disable iff (rst)
        ins_strobe |=> valid_q[$past(ins_idx)] && !used_q[$past(ins_idx)]);

    assert_overlap_cleared_R7: assert property (@(posedge clk) disable iff (rst)
        ins_strobe |=> ((valid_q & $past(overlap_vec & ~ins_onehot)) == '0));
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlbv_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = $clog2(NUM_ENTRIES),
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_strobe,
    input  logic                   force_en,
    input  logic [IDX_W-1:0]       force_idx,
    input  logic [NUM_ENTRIES-1:0] overlap_vec,
    input  logic [NUM_ENTRIES-1:0] lock_vec,
    input  logic                   touch_en,
    input  logic [IDX_W-1:0]       touch_idx,
    output logic [IDX_W-1:0]       victim_idx,
    output logic                   all_locked,
    output logic [NUM_ENTRIES-1:0] valid_vec,
    output logic [NUM_ENTRIES-1:0] used_vec,
    output logic [CNT_W-1:0]       used_count
);
    logic [IDX_W-1:0]       last_ptr;
    logic [NUM_ENTRIES-1:0] free_mask;
    logic                   free_found;
    logic [IDX_W-1:0]       free_idx;
    logic                   srch_found;
    logic [IDX_W-1:0]       srch_idx;
    victim_src_e            src;

    assign free_mask = ~valid_vec | overlap_vec;

    tlbv_free_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_free (
        .free_mask (free_mask),
        .found     (free_found),
        .idx       (free_idx)
    );

    tlbv_rr_search #(.NUM_ENTRIES(NUM_ENTRIES)) u_search (
        .last_ptr (last_ptr),
        .lock_vec (lock_vec),
        .found    (srch_found),
        .idx      (srch_idx)
    );

    always_comb begin
        if (force_en) begin
            src        = SRC_FORCED;
            victim_idx = force_idx;
        end else if (free_found) begin
            src        = SRC_FREE;
            victim_idx = free_idx;
        end else if (srch_found) begin
            src        = SRC_SEARCH;
            victim_idx = srch_idx;
        end else begin
            src        = SRC_FALLBACK;
            victim_idx = IDX_W'(NUM_ENTRIES - 1);
        end
    end

    assign all_locked = (src == SRC_FALLBACK);

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ptr <= IDX_W'(NUM_ENTRIES - 1);
        end else if (ins_strobe && src == SRC_SEARCH) begin
            last_ptr <= victim_idx;
        end
    end

    tlbv_entry_state #(.NUM_ENTRIES(NUM_ENTRIES)) u_state (
        .clk         (clk),
        .rst         (rst),
        .ins_strobe  (ins_strobe),
        .ins_idx     (victim_idx),
        .overlap_vec (overlap_vec),
        .touch_en    (touch_en),
        .touch_idx   (touch_idx),
        .valid_q     (valid_vec),
        .used_q      (used_vec),
        .count_q     (used_count)
    );

    assert_force_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        force_en |-> int'(force_idx) < NUM_ENTRIES);

    assert_force_wins_R2: assert property (@(posedge clk) disable iff (rst)
        force_en |-> victim_idx == force_idx && !all_locked);

    assert_free_victim_empty_R3: assert property (@(posedge clk) disable iff (rst)
        (!force_en && free_mask != '0) |-> free_mask[victim_idx] && !all_locked);

    assert_search_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_SEARCH) |-> !lock_vec[victim_idx] && victim_idx != last_ptr);

    assert_fallback_top_R5: assert property (@(posedge clk) disable iff (rst)
        all_locked |-> int'(victim_idx) == NUM_ENTRIES - 1 && free_mask == '0 && !force_en);

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ins_strobe && src != SRC_SEARCH) |=> $stable(last_ptr));

    assert_ptr_load_R6: assert property (@(posedge clk) disable iff (rst)
        (ins_strobe && src == SRC_SEARCH) |=> last_ptr == $past(victim_idx));
endmodule

// File: tb/tlb_victim_sel_test.sv
module tlb_victim_sel_test;
    localparam int N     = 8;
    localparam int IW    = $clog2(N);
    localparam int CW    = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_strobe;
    logic          force_en;
    logic [IW-1:0] force_idx;
    logic [N-1:0]  overlap_vec;
    logic [N-1:0]  lock_vec;
    logic          touch_en;
    logic [IW-1:0] touch_idx;
    logic [IW-1:0] victim_idx;
    logic          all_locked;
    logic [N-1:0]  valid_vec;
    logic [N-1:0]  used_vec;
    logic [CW-1:0] used_count;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_valid;
    logic [N-1:0] m_used;
    int           m_ptr;

    always #10 clk = ~clk;

    tlb_victim_sel #(.NUM_ENTRIES(N)) uut (
        .clk(clk), .rst(rst), .ins_strobe(ins_strobe), .force_en(force_en),
        .force_idx(force_idx), .overlap_vec(overlap_vec), .lock_vec(lock_vec),
        .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(victim_idx),
        .all_locked(all_locked), .valid_vec(valid_vec), .used_vec(used_vec),
        .used_count(used_count)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // kind: 0 forced, 1 free, 2 search, 3 fallback
    task automatic predict(input bit fen, input int fidx, input logic [N-1:0] ovl,
                           input logic [N-1:0] lck, output int v, output int kind);
        logic [N-1:0] freem;
        int slot;
        freem = ~m_valid | ovl;
        if (fen) begin
            v = fidx; kind = 0;
        end else if (freem != '0) begin
            v = 0;
            while (!freem[v]) v++;
            kind = 1;
        end else begin
            kind = 3; v = N - 1;
            slot = m_ptr;
            for (int k = 1; k < N; k++) begin
                slot = (slot + 1) % N;
                if (kind == 3 && !lck[slot]) begin
                    v = slot; kind = 2;
                end
            end
        end
    endtask

    function automatic int popc(logic [N-1:0] x);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(x[i]);
        return c;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(bit ins, bit fen, int fidx, logic [N-1:0] ovl,
                        logic [N-1:0] lck, bit ten, int tidx);
        int v, kind;
        string vreq;
        ins_strobe = ins; force_en = fen; force_idx = IW'(fidx);
        overlap_vec = ovl; lock_vec = lck; touch_en = ten; touch_idx = IW'(tidx);
        #1;
        predict(fen, fidx, ovl, lck, v, kind);
        case (kind)
            0: vreq = "R2";
            1: vreq = "R3";
            2: vreq = "R4 R6";
            default: vreq = "R5";
        endcase
        check(int'(victim_idx) == v, vreq, "victim_idx", victim_idx, v);
        check(all_locked == (kind == 3), (kind == 3) ? "R5" : "R10", "all_locked",
              all_locked, kind == 3);
        @(posedge clk);
        if (ins) begin
            m_valid = (m_valid & ~ovl);
            m_used  = m_used & ~ovl;
            m_valid[v] = 1'b1;
            m_used[v]  = 1'b0;
            if (kind == 2) m_ptr = v;
        end else if (ten && m_valid[tidx]) begin
            m_used[tidx] = 1'b1;
        end
        @(negedge clk);
        check(valid_vec == m_valid, "R7", "valid_vec", valid_vec, m_valid);
        check(used_vec == m_used, "R8", "used_vec", used_vec, m_used);
        check(int'(used_count) == popc(m_used), "R9", "used_count", used_count, popc(m_used));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        rst = 1'b1; ins_strobe = 0; force_en = 0; force_idx = '0;
        overlap_vec = '0; lock_vec = '0; touch_en = 0; touch_idx = '0;
        m_valid = '0; m_used = '0; m_ptr = N - 1;
        seed_dummy = $urandom(32'h5eed_1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(valid_vec == '0, "R1", "valid_vec", valid_vec, 0);
        check(used_vec == '0, "R1", "used_vec", used_vec, 0);
        check(used_count == '0, "R1", "used_count", used_count, 0);
        check(victim_idx == '0 && !all_locked, "R1", "victim_idx", victim_idx, 0);
        @(negedge clk);

        // R3: fill lowest-first
        for (int i = 0; i < N; i++) step(1, 0, 0, '0, '0, 0, 0);
        check(valid_vec == '1, "R3", "filled", valid_vec, 8'hff);
        // R8: touches, repeat touch, touch during insert ignored
        step(0, 0, 0, '0, '0, 1, 2);
        step(0, 0, 0, '0, '0, 1, 5);
        step(0, 0, 0, '0, '0, 1, 5);
        check(used_count == 2, "R8", "repeat touch count", used_count, 2);
        // R1 R4: first eviction is slot 0 (pointer reset to N-1)
        step(1, 0, 0, '0, '0, 1, 6);
        check(used_vec[6] == 1'b0, "R8", "touch with insert", used_vec[6], 0);
        step(1, 0, 0, '0, 8'b0000_0110, 0, 0);   // skips 1,2 -> 3
        check(victim_idx == 3'd4, "R4", "next after 3", victim_idx, 4);
        // R5: only pointer slot (3) unlocked -> fallback to 7, pointer kept
        step(1, 0, 0, '0, 8'b1111_0111, 0, 0);
        step(1, 0, 0, '0, '0, 0, 0);             // resumes at 4
        // R2: forced insert with everything locked, pointer kept
        step(1, 1, 1, '0, '1, 0, 0);
        step(0, 0, 0, '0, '0, 0, 0);
        check(victim_idx == 3'd5, "R2", "pointer after force", victim_idx, 5);
        // R7 R3: overlap frees used slot 5 and slot 2
        step(0, 0, 0, '0, '0, 1, 5);
        step(1, 0, 0, 8'b0010_0100, '1, 0, 0);
        check(valid_vec[5] == 1'b0 && valid_vec[2], "R7", "overlap", valid_vec, 8'hdf);

        // random phase
        for (int it = 0; it < 3000; it++) begin
            bit ins, fen, ten;
            logic [N-1:0] ovl, lck;
            ins = ($urandom % 3) != 0;
            fen = ($urandom % 8) == 0;
            ten = ($urandom % 2) == 0;
            ovl = (($urandom % 6) == 0) ? N'(1 << ($urandom % N)) : '0;
            lck = N'($urandom) | N'($urandom) | N'($urandom);
            if (($urandom % 5) == 0) lck = '1;
            step(ins, fen, int'($urandom % N), ovl, lck, ten, int'($urandom % N));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule